// File: doc/BRIEF.md
# Two-Class Windowed Priority Arbiter

This block shares one memory port among several initiator threads, each of which belongs to one of two traffic classes. A free-running window counter hands high priority to class one for a programmable number of cycles, then to class two for its own programmable number of cycles, and repeats. At each arbitration decision the favoured class wins if any of its threads is requesting. If the favoured class has nothing pending, the other class is served, so the port never sits idle while a request is pending. Within a class, threads take turns in round-robin order.

Once granted, a thread keeps the port for a programmable number of consecutive split transactions. It signals each one on its transaction-done input. The grant is released early if the thread withdraws its request. When a grant is released, the next decision is taken on the same clock edge, so grants follow one another with no gap. A small register port holds both window lengths and one service count per thread.

Top module: `tca_arbiter`

## Requirements
- R1: After reset no grant is asserted. Register 0 reads 0x00400040, which means both window lengths are 64. Registers 1 to 3 read 1, the service count of threads 0 to 2.
- R2: Register 0 holds the class-one window in bits 7:0 and the class-two window in bits 23:16. Register 1+t holds the service count of thread t in bits 4:0. Every other bit ignores writes and reads as zero.
- R3: The first window after reset favours class one. The favoured class then alternates, and each class keeps priority for its programmed number of cycles. Over any full period with all threads requesting and one service per grant, class one receives exactly its window length of grants.
- R4: A window length written as zero behaves as a length of one cycle.
- R5: When the favoured class has no pending request and the other class does, the other class is granted.
- R6: Threads of one class are granted round-robin, starting after the thread of that class granted last.
- R7: A granted thread keeps the grant until it has pulsed done as many times as its service count. Done pulses from threads that do not hold the grant have no effect.
- R8: A service count of zero behaves as one.
- R9: A grant is released when the owner drops its request. A window change never preempts a grant that is still held.
- R10: The grant vector is zero or one-hot.
- R11: When a grant is released, or no grant is held, the new decision is registered on the same edge. No cycle without a grant follows while any request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NUM_THR | Per-thread request, held while the thread wants the port |
| done | input | NUM_THR | Per-thread pulse, one cycle per completed split transaction |
| gnt | output | NUM_THR | One-hot registered grant |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 32 | Register read data (combinational) |

## Verification
Two events can fall in the same cycle: a window boundary and the release of a grant by a completing done pulse. With windows of one or two cycles and every grant finishing in one cycle, nearly every decision lands on a boundary. The bench counts grants per class over a full period and requires the exact window lengths, with no cycle left without a grant. A held grant is also checked across several boundaries to confirm that a flip alone never moves it.

// File: rtl/tca_pkg.sv
package tca_pkg;
   localparam int DATA_W   = 32;
   localparam int WIN_W    = 8;
   localparam int ROT_W    = 5;
   localparam int WIN1_LSB = 0;
   localparam int WIN2_LSB = 16;
   localparam logic [WIN_W-1:0] WIN_RST = 8'd64;
   localparam logic [ROT_W-1:0] ROT_RST = 5'd1;
endpackage

// File: rtl/tca_regs.sv
module tca_regs
   import tca_pkg::*;
#(
   parameter int NUM_THR = 3,
   parameter int AW      = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [AW-1:0]            rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic [WIN_W-1:0]         win1,
   output logic [WIN_W-1:0]         win2,
   output logic [NUM_THR*ROT_W-1:0] rot_flat
);
   logic [WIN_W-1:0] w1_q, w2_q;
   logic [ROT_W-1:0] rot_q [NUM_THR];
   logic [DATA_W-WIN2_LSB-WIN_W-1:0] unused_hi;
   logic [WIN2_LSB-WIN1_LSB-WIN_W-1:0] unused_mid;

   initial begin
      if (NUM_THR + 1 > (1 << AW)) $error("tca_regs: AW too small for NUM_THR");
      if (WIN2_LSB < WIN1_LSB + WIN_W) $error("tca_regs: window fields overlap");
   end

   assign unused_hi  = wr_data[DATA_W-1:WIN2_LSB+WIN_W];
   assign unused_mid = wr_data[WIN2_LSB-1:WIN1_LSB+WIN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w1_q <= WIN_RST;
         w2_q <= WIN_RST;
      end else if (wr_en && wr_addr == '0) begin
         w1_q <= wr_data[WIN1_LSB +: WIN_W];
         w2_q <= wr_data[WIN2_LSB +: WIN_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < NUM_THR; t++) rot_q[t] <= ROT_RST;
      end else if (wr_en) begin
         for (int t = 0; t < NUM_THR; t++)
            if (wr_addr == AW'(t + 1)) rot_q[t] <= wr_data[ROT_W-1:0];
      end
   end

   generate
      for (genvar t = 0; t < NUM_THR; t++) begin : g_flat
         assign rot_flat[t*ROT_W +: ROT_W] = rot_q[t];
      end
   endgenerate

   assign win1 = w1_q;
   assign win2 = w2_q;

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) begin
         rd_data[WIN1_LSB +: WIN_W] = w1_q;
         rd_data[WIN2_LSB +: WIN_W] = w2_q;
      end else begin
         for (int t = 0; t < NUM_THR; t++)
            if (rd_addr == AW'(t + 1)) rd_data[ROT_W-1:0] = rot_q[t];
      end
   end
endmodule

// File: rtl/tca_window.sv
module tca_window
   import tca_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIN_W-1:0] len1_raw,
   input  logic [WIN_W-1:0] len2_raw,
   output logic             hi2
);
   logic [WIN_W-1:0] cnt_q, len1, len2, cur_len;
   logic             wrap;

   assign len1    = (len1_raw == '0) ? WIN_W'(1) : len1_raw;
   assign len2    = (len2_raw == '0) ? WIN_W'(1) : len2_raw;
   assign cur_len = hi2 ? len2 : len1;
   assign wrap    = (cnt_q >= cur_len - WIN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi2   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         hi2   <= ~hi2;
      end else begin
         cnt_q <= cnt_q + WIN_W'(1);
      end
   end

   // R3
   flip_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi2 != $past(hi2)) |-> (cnt_q == '0));
endmodule

// File: rtl/tca_rrpick.sv
module tca_rrpick #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic [N-1:0]  pick,
   output logic          any
);
   initial begin
      if (N < 1) $error("tca_rrpick: N must be positive");
   end

   always_comb begin
      logic found;
      found = 1'b0;
      pick  = '0;
      for (int k = 1; k <= N; k++) begin
         int idx;
         idx = (int'(last) + k) % N;
         if (!found && req[idx]) begin
            pick[idx] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   assign any = |req;
endmodule

// File: rtl/tca_arbiter.sv
module tca_arbiter
   import tca_pkg::*;
#(
   parameter int                   NUM_THR   = 3,
   parameter logic [NUM_THR-1:0]   CLS2_MASK = 3'b100,
   parameter int                   AW        = $clog2(NUM_THR + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_THR-1:0] req,
   input  logic [NUM_THR-1:0] done,
   output logic [NUM_THR-1:0] gnt,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int IW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;

   initial begin
      if (NUM_THR < 2) $error("tca_arbiter: need at least two threads");
   end

   logic [WIN_W-1:0]         win1, win2;
   logic [NUM_THR*ROT_W-1:0] rot_flat;
   logic                     hi2;
   logic [NUM_THR-1:0]       gnt_q, pick;
   logic [NUM_THR-1:0]       cls_pick [2];
   logic [1:0]               cls_any;
   logic [IW-1:0]            last_q [2];
   logic [ROT_W-1:0]         served_q, lim;
   logic                     own_req, own_done, limit_hit, release_now, free;

   tca_regs #(.NUM_THR(NUM_THR), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .win1(win1), .win2(win2), .rot_flat(rot_flat)
   );

   tca_window u_win (
      .clk(clk), .rst_n(rst_n), .len1_raw(win1), .len2_raw(win2), .hi2(hi2)
   );

   generate
      for (genvar c = 0; c < 2; c++) begin : g_cls
         logic [NUM_THR-1:0] member;
         assign member = (c == 1) ? CLS2_MASK : ~CLS2_MASK;
         tca_rrpick #(.N(NUM_THR), .IW(IW)) u_pick (
            .req(req & member), .last(last_q[c]),
            .pick(cls_pick[c]), .any(cls_any[c])
         );
      end
   endgenerate

   always_comb begin
      if (hi2) pick = cls_any[1] ? cls_pick[1] : cls_pick[0];
      else     pick = cls_any[0] ? cls_pick[0] : cls_pick[1];
   end

   always_comb begin
      lim = ROT_W'(1);
      for (int t = 0; t < NUM_THR; t++)
         if (gnt_q[t] && rot_flat[t*ROT_W +: ROT_W] != '0)
            lim = rot_flat[t*ROT_W +: ROT_W];
   end

   assign own_req     = |(gnt_q & req);
   assign own_done    = |(gnt_q & done);
   assign limit_hit   = ({1'b0, served_q} + (ROT_W+1)'(1)) >= {1'b0, lim};
   assign release_now = !own_req || (own_done && limit_hit);
   assign free        = (gnt_q == '0) || release_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q    <= '0;
         served_q <= '0;
         last_q[0] <= '0;
         last_q[1] <= '0;
      end else if (free) begin
         gnt_q    <= pick;
         served_q <= '0;
         for (int t = 0; t < NUM_THR; t++)
            if (pick[t]) last_q[CLS2_MASK[t]] <= IW'(t);
      end else if (own_done) begin
         served_q <= served_q + ROT_W'(1);
      end
   end

   assign gnt = gnt_q;

   // R10
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));

   // R11
   no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q == '0 && req != '0) |=> (gnt_q != '0));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q != '0 && own_req && !own_done) |=> $stable(gnt_q));

   // R9
   drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q != '0 && !own_req) |=> ((gnt_q & $past(gnt_q)) == '0));
endmodule

// File: tb/tca_arbiter_test.sv
module tca_arbiter_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  req = 3'b111;
   logic [2:0]  man_done = 3'b000;
   logic        auto_done = 1'b1;
   logic [2:0]  done, gnt;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;
   assign done = auto_done ? gnt : man_done;

   tca_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req(req), .done(done), .gnt(gnt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic tally(input int n, output int c1, output int c2,
                        output int t0, output int t1, output int idle);
      c1 = 0; c2 = 0; t0 = 0; t1 = 0; idle = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (gnt == 3'b000) idle++;
         if (gnt[0] || gnt[1]) c1++;
         if (gnt[2]) c2++;
         if (gnt[0]) t0++;
         if (gnt[1]) t1++;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int c1, c2, t0, t1, idle, g;
      int lens [5] = '{0, 1, 2, 3, 7};

      repeat (3) @(negedge clk);
      check("R1 gnt in reset", int'(gnt), 0);
      rd(2'd0, d); check("R1 window reset", int'(d), 32'h0040_0040);
      for (int a = 1; a < 4; a++) begin
         rd(2'(a), d); check("R1 service reset", int'(d), 1);
      end

      rst_n = 1'b1;
      tally(64, c1, c2, t0, t1, idle);
      check("R3 first window class1", c1, 64);
      check("R6 round robin share", t0, 32);
      tally(64, c1, c2, t0, t1, idle);
      check("R3 second window class2", c2, 64);

      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R2 reserved window bits", int'(d), 32'h00FF_00FF);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d); check("R2 reserved service bits", int'(d), 32'h1F);
      wr(2'd1, 32'd1);

      foreach (lens[i]) begin
         foreach (lens[j]) begin
            int e1, e2;
            e1 = (lens[i] == 0) ? 1 : lens[i];
            e2 = (lens[j] == 0) ? 1 : lens[j];
            wr(2'd0, {8'h00, 8'(lens[j]), 8'h00, 8'(lens[i])});
            repeat (e1 + e2 + 3) @(negedge clk);
            tally(2 * (e1 + e2), c1, c2, t0, t1, idle);
            if (lens[i] == 0 || lens[j] == 0)
               check("R4 zero window as one", c1, 2 * e1);
            else
               check("R3 class1 share", c1, 2 * e1);
            check("R11 no idle cycle", idle, 0);
         end
      end

      wr(2'd0, {8'h00, 8'd1, 8'h00, 8'd100});
      req = 3'b100;
      repeat (3) @(negedge clk);
      tally(100, c1, c2, t0, t1, idle);
      check("R5 class2 alone granted", c2, 100);
      wr(2'd0, {8'h00, 8'd100, 8'h00, 8'd1});
      req = 3'b011;
      repeat (3) @(negedge clk);
      tally(100, c1, c2, t0, t1, idle);
      check("R5 class1 alone granted", c1, 100);
      check("R6 alternate threads", t0, 50);

      wr(2'd1, 32'd3);
      repeat (8) @(negedge clk);
      tally(40, c1, c2, t0, t1, idle);
      check("R7 three services", t0, 30);
      wr(2'd1, 32'd0);
      repeat (8) @(negedge clk);
      tally(40, c1, c2, t0, t1, idle);
      check("R8 zero service as one", t0, 20);
      wr(2'd1, 32'd31);
      repeat (40) @(negedge clk);
      tally(64, c1, c2, t0, t1, idle);
      check("R7 max services", t0, 62);
      wr(2'd1, 32'd1);

      wr(2'd0, {8'h00, 8'd4, 8'h00, 8'd4});
      auto_done = 1'b0;
      man_done = 3'b000;
      req = 3'b111;
      repeat (3) @(negedge clk);
      g = int'(gnt);
      check("R10 single grant", $countones(gnt), 1);
      c1 = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (int'(gnt) != g) c1++;
      end
      check("R9 held across windows", c1, 0);
      man_done = ~3'(g);
      repeat (5) @(negedge clk);
      man_done = 3'b000;
      @(negedge clk);
      check("R7 foreign done ignored", int'(gnt), g);
      req = 3'b111 & ~3'(g);
      @(negedge clk);
      check("R9 drop releases", int'((gnt & 3'(g)) != 0), 0);
      check("R11 immediate regrant", int'(gnt != 0), 1);

      req = 3'b011;
      wr(2'd1, 32'd2);
      wr(2'd2, 32'd2);
      repeat (2) @(negedge clk);
      g = int'(gnt);
      man_done = 3'(g);
      @(negedge clk);
      man_done = 3'b000;
      check("R7 one of two services", int'(gnt), g);
      man_done = 3'(g);
      @(negedge clk);
      man_done = 3'b000;
      check("R7 second service releases", int'(gnt), (g == 1) ? 2 : 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule